// File: doc/BRIEF.md
# Multi-format host bus adapter

This block sits between a host processor bus and a small bank of byte-wide registers. It accepts four host bus styles: Intel-style cycles with separate active-low read and write strobes, or Motorola-style cycles with an active-high data strobe and a read/write direction line. Either style can come with its own 4-bit address bus, or with the address sent on the low nibble of the shared 8-bit address/data bus. It turns each host cycle into a one-clock read-enable or write-enable pulse on the internal register side. It returns read data and controls the direction of the data bus.

Two strap pins are captured while reset is held low and stay fixed until the next reset. The multiplex strap is active low: low selects the shared address/data bus. The style strap selects Intel style when high and Motorola style when low. In multiplexed mode the style pin then acts as the address latch strobe. All host controls pass through a two-stage synchroniser into a controller with five states:

- IDLE waits for a cycle. It goes to FETCH when a read is seen, or to WRITE when a write is seen. A read takes priority when both are seen together.
- FETCH pulses the read enable and captures the register data. It goes to DRIVE if the read is still active, and otherwise back to IDLE.
- DRIVE enables the data bus output. It stays there while the read lasts and returns to IDLE when the read ends.
- WRITE follows the host data. It goes to COMMIT when the write strobe or the chip enable is released.
- COMMIT issues the single write-enable pulse and then returns to IDLE.

Top module: `host_bus_adapter`

## Requirements
- R1: While `rst_n` is low, the controller returns to IDLE, `ad_oe` is 0, and no `reg_we` or `reg_re` pulse occurs.
- R2: When `mult_n` is low during reset, the register address is taken from `ad_in[3:0]` while the synchronised `as_mi` is high in IDLE. `ad_in[7:4]` and `addr_in` have no effect on the address.
- R3: When `mult_n` is high during reset, `addr_in` is sampled once, at the start of the strobe. Changes to `addr_in` later in the same cycle have no effect.
- R4: When `as_mi` is 1 during reset, the style is Intel: `rd_ds` low means read and `wr_rw` low means write. When `as_mi` is 0 during reset, the style is Motorola: `rd_ds` high is the data strobe, and `wr_rw` selects read when 1 and write when 0.
- R5: Each write cycle produces exactly one `reg_we` pulse, one clock long. The pulse comes after the strobe or the chip enable is released. It carries the latched address and the last data seen on `ad_in`.
- R6: Each read cycle produces one `reg_re` pulse, one clock long, at its start. The `rd_data` value sampled during that pulse is presented on `ad_out`.
- R7: `ad_oe` is 1 only while a synchronised read cycle with chip enable is active. It returns to 0 within 4 clocks after the strobe is released.
- R8: While `cs_n` is high, no cycle is recognised: no `reg_we` pulse, no `reg_re` pulse, and `ad_oe` stays 0.
- R9: The multiplex and style straps keep their captured values after reset is released, whatever the pins do afterwards.
- R10: A reset applied in the middle of a write cycle abandons that cycle, and no `reg_we` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset; straps are sampled while it is low |
| cs_n | input | 1 | Active-low chip enable |
| mult_n | input | 1 | Multiplex strap, low selects the shared address/data bus |
| as_mi | input | 1 | Style strap at reset; address latch strobe in multiplexed mode |
| rd_ds | input | 1 | Intel read strobe (low) or Motorola data strobe (high) |
| wr_rw | input | 1 | Intel write strobe (low) or Motorola direction (1 read, 0 write) |
| addr_in | input | 4 | Separate address bus (non-multiplexed mode) |
| ad_in | input | 8 | Data bus input, also carries the address in multiplexed mode |
| ad_out | output | 8 | Data bus output value |
| ad_oe | output | 1 | Data bus output enable |
| rd_data | input | 8 | Read data from the register bank |
| reg_addr | output | 4 | Latched register address |
| reg_wdata | output | 8 | Write data to the register bank |
| reg_we | output | 1 | One-clock write enable |
| reg_re | output | 1 | One-clock read enable |

## Verification
Writes and reads are run in all four combinations of strap and style. A register written in one cycle is read back in a later cycle. In multiplexed runs, the upper address nibble and the unused address pins are set to misleading values. This separates a correct low-nibble decode from a design that takes its address from the wrong source. The other scenarios cover:

- Changing `addr_in` in the middle of a strobe, to show the address is sampled at strobe start rather than at the end.
- Strobes with the chip enable high, to show that no cycle is recognised.
- Moving the strap pins after reset, to show that the captured mode does not track the pins.
- Asserting reset in the middle of a write, to show that no late write pulse appears.

// File: rtl/hba_pkg.sv
package hba_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_DRIVE  = 3'd2,
        ST_WRITE  = 3'd3,
        ST_COMMIT = 3'd4
    } hba_state_e;

    typedef enum logic {
        STYLE_MOTO  = 1'b0,
        STYLE_INTEL = 1'b1
    } hba_style_e;

endpackage

// File: rtl/hba_sync.sv
module hba_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [WIDTH-1:0] src;
        if (i == 0) begin : g_first
            assign src = d;
        end else begin : g_next
            assign src = stage_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RST_VAL;
            else        stage_q[i] <= src;
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hba_strap.sv
module hba_strap
    import hba_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mult_n_pin,
    input  logic       style_pin,
    output logic       mux_mode,
    output hba_style_e style
);

    // Straps follow the pins only while reset is held low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_mode <= ~mult_n_pin;
            style    <= hba_style_e'(style_pin);
        end
    end

    // R9
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(mux_mode) && $stable(style)));

endmodule

// File: rtl/hba_decode.sv
module hba_decode
    import hba_pkg::*;
(
    input  hba_style_e style,
    input  logic       cs_s,
    input  logic       rd_s,
    input  logic       wr_s,
    output logic       rd_act,
    output logic       wr_act
);

    always_comb begin
        rd_act = 1'b0;
        wr_act = 1'b0;
        if (!cs_s) begin
            unique case (style)
                STYLE_INTEL: begin
                    rd_act = ~rd_s;
                    wr_act = rd_s & ~wr_s;
                end
                STYLE_MOTO: begin
                    rd_act = rd_s & wr_s;
                    wr_act = rd_s & ~wr_s;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/hba_fsm.sv
module hba_fsm
    import hba_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mux_mode,
    input  logic              rd_act,
    input  logic              wr_act,
    input  logic              ale_s,
    input  logic [ADDR_W-1:0] addr_pins,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe
);

    hba_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rbuf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_act)      state_d = ST_FETCH;
                else if (wr_act) state_d = ST_WRITE;
            end
            ST_FETCH:  state_d = rd_act ? ST_DRIVE : ST_IDLE;
            ST_DRIVE:  state_d = rd_act ? ST_DRIVE : ST_IDLE;
            ST_WRITE:  state_d = wr_act ? ST_WRITE : ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rbuf_q  <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                if (mux_mode) begin
                    if (ale_s) addr_q <= ad_in[ADDR_W-1:0];
                end else if (rd_act || wr_act) begin
                    addr_q <= addr_pins;
                end
            end
            if (state_q == ST_WRITE && wr_act) wdata_q <= ad_in;
            if (state_q == ST_FETCH)           rbuf_q  <= rd_data;
        end
    end

    always_comb begin
        reg_we = 1'b0;
        reg_re = 1'b0;
        ad_oe  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FETCH:  reg_re = 1'b1;
            ST_DRIVE:  ad_oe  = 1'b1;
            ST_WRITE:  ;
            ST_COMMIT: reg_we = 1'b1;
            default:   ;
        endcase
    end

    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;
    assign ad_out    = rbuf_q;

    // R5
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R5
    we_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !$past(wr_act));

    // R6
    re_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    // R6
    re_then_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && rd_act) |=> ad_oe);

    // R7
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> $past(rd_act));

endmodule

// File: rtl/host_bus_adapter.sv
module host_bus_adapter
    import hba_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              mult_n,
    input  logic              as_mi,
    input  logic              rd_ds,
    input  logic              wr_rw,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re
);

    localparam int CTRL_W = 4;
    localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b1011;

    logic [CTRL_W-1:0] ctrl_s;
    logic       cs_s, ale_s, rd_s, wr_s;
    logic       mux_mode;
    hba_style_e style;
    logic       rd_act, wr_act;

    hba_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, as_mi, rd_ds, wr_rw}),
        .q     (ctrl_s)
    );

    assign {cs_s, ale_s, rd_s, wr_s} = ctrl_s;

    hba_strap u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .mult_n_pin (mult_n),
        .style_pin  (as_mi),
        .mux_mode   (mux_mode),
        .style      (style)
    );

    hba_decode u_decode (
        .style  (style),
        .cs_s   (cs_s),
        .rd_s   (rd_s),
        .wr_s   (wr_s),
        .rd_act (rd_act),
        .wr_act (wr_act)
    );

    hba_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mux_mode  (mux_mode),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .ale_s     (ale_s),
        .addr_pins (addr_in),
        .ad_in     (ad_in),
        .rd_data   (rd_data),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe)
    );

    // R8
    re_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> !$past(cs_s));

    // R8
    we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_we) |-> !$past(cs_s, 2));

endmodule

// File: tb/tb_host_bus_adapter.sv
module tb_host_bus_adapter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, mult_n = 1'b1, as_mi = 1'b1;
    logic       rd_ds = 1'b1, wr_rw = 1'b1;
    logic [3:0] addr_in = '0;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out, rd_data, reg_wdata;
    logic       ad_oe, reg_we, reg_re;
    logic [3:0] reg_addr;

    int tests = 0, fails = 0;
    int we_cnt = 0, re_cnt = 0;
    logic [3:0] we_addr;
    logic [7:0] we_data;
    logic [7:0] rf [16];
    bit mux_m, intel_m, done = 0;

    always #10 clk = ~clk;

    host_bus_adapter dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mult_n(mult_n), .as_mi(as_mi),
        .rd_ds(rd_ds), .wr_rw(wr_rw), .addr_in(addr_in), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .rd_data(rd_data), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re)
    );

    assign rd_data = rf[reg_addr];

    always @(posedge clk) begin
        if (reg_we === 1'b1) begin
            we_cnt++;
            we_addr = reg_addr;
            we_data = reg_wdata;
            rf[reg_addr] = reg_wdata;
        end
        if (reg_re === 1'b1) re_cnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit mux, input bit intel);
        @(negedge clk);
        mux_m = mux; intel_m = intel;
        mult_n = ~mux; as_mi = intel;
        rd_ds = intel; wr_rw = 1'b1; cs_n = 1'b1;
        rst_n = 1'b0;
        cycles(4);
        rst_n = 1'b1;
        if (mux) as_mi = 1'b0;
        cycles(3);
    endtask

    task automatic addr_phase(input logic [3:0] a);
        if (mux_m) begin
            ad_in = {4'hA, a};
            addr_in = ~a;
            as_mi = 1'b1;
            cycles(4);
            as_mi = 1'b0;
            cycles(4);
        end else begin
            addr_in = a;
            ad_in = {4'h5, ~a};
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        addr_phase(a);
        @(negedge clk);
        ad_in = d; cs_n = 1'b0; wr_rw = 1'b0;
        if (!intel_m) rd_ds = 1'b1;
        cycles(6);
        cs_n = 1'b1;
        if (intel_m) wr_rw = 1'b1; else rd_ds = 1'b0;
        cycles(6);
        wr_rw = 1'b1;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [7:0] d, output logic oe_mid, output logic oe_after);
        addr_phase(a);
        @(negedge clk);
        ad_in = 8'h00; cs_n = 1'b0; wr_rw = 1'b1;
        rd_ds = intel_m ? 1'b0 : 1'b1;
        cycles(8);
        d = ad_out; oe_mid = ad_oe;
        cs_n = 1'b1; rd_ds = intel_m ? 1'b1 : 1'b0;
        cycles(5);
        oe_after = ad_oe;
    endtask

    task automatic t_reset_state;
        do_reset(1'b0, 1'b1);
        check(ad_oe == 1'b0, "R1 oe after reset", ad_oe, 0);
        check(we_cnt == 0 && re_cnt == 0, "R1 no pulses", we_cnt + re_cnt, 0);
    endtask

    task automatic t_intel_sep;
        logic [7:0] d; logic om, oa; int w0, r0;
        do_reset(1'b0, 1'b1);
        w0 = we_cnt;
        do_write(4'h5, 8'hA5);
        check(we_cnt == w0 + 1, "R5 one write pulse", we_cnt - w0, 1);
        check(we_addr == 4'h5 && we_data == 8'hA5, "R4 intel write", {we_addr, we_data}, 12'h5A5);
        r0 = re_cnt;
        do_read(4'h5, d, om, oa);
        check(d == 8'hA5, "R6 intel read data", d, 8'hA5);
        check(re_cnt == r0 + 1, "R6 one read pulse", re_cnt - r0, 1);
        check(om == 1'b1, "R7 oe during read", om, 1);
        check(oa == 1'b0, "R7 oe released", oa, 0);
    endtask

    task automatic t_addr_sample;
        int w0;
        w0 = we_cnt;
        addr_in = 4'h3;
        @(negedge clk);
        ad_in = 8'h33; cs_n = 1'b0; wr_rw = 1'b0;
        cycles(6);
        addr_in = 4'hE;
        cycles(3);
        cs_n = 1'b1; wr_rw = 1'b1;
        cycles(6);
        check(we_cnt == w0 + 1 && we_addr == 4'h3, "R3 address at strobe start", we_addr, 3);
    endtask

    task automatic t_cs_high;
        int w0, r0; logic oe_seen;
        w0 = we_cnt; r0 = re_cnt; oe_seen = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wr_rw = 1'b0; addr_in = 4'h5; ad_in = 8'hFF;
        cycles(6);
        wr_rw = 1'b1;
        cycles(2);
        rd_ds = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            oe_seen |= ad_oe;
        end
        rd_ds = 1'b1;
        cycles(6);
        check(we_cnt == w0 && re_cnt == r0, "R8 no pulses with cs high", (we_cnt - w0) + (re_cnt - r0), 0);
        check(oe_seen == 1'b0, "R8 oe stays low", oe_seen, 0);
        check(rf[5] == 8'hA5, "R8 register untouched", rf[5], 8'hA5);
    endtask

    task automatic t_moto_sep;
        logic [7:0] d; logic om, oa;
        do_reset(1'b0, 1'b0);
        do_write(4'hC, 8'h3C);
        check(we_addr == 4'hC && we_data == 8'h3C, "R4 moto write", {we_addr, we_data}, 12'hC3C);
        do_read(4'hC, d, om, oa);
        check(d == 8'h3C && om == 1'b1, "R4 moto read", d, 8'h3C);
        check(oa == 1'b0, "R7 moto oe released", oa, 0);
    endtask

    task automatic t_mux(input bit intel, input logic [3:0] a, input logic [7:0] v);
        logic [7:0] d; logic om, oa;
        do_reset(1'b1, intel);
        do_write(a, v);
        check(we_addr == a && we_data == v, "R2 mux write low nibble", {we_addr, we_data}, {a, v});
        do_read(a, d, om, oa);
        check(d == v && om == 1'b1, "R2 mux read", d, v);
    endtask

    task automatic t_strap_hold;
        logic [7:0] d; logic om, oa;
        do_reset(1'b0, 1'b1);
        mult_n = 1'b0;
        as_mi = 1'b0;
        do_write(4'h7, 8'h71);
        check(we_addr == 4'h7 && we_data == 8'h71, "R9 straps held", {we_addr, we_data}, 12'h771);
        do_read(4'h7, d, om, oa);
        check(d == 8'h71, "R9 straps held read", d, 8'h71);
    endtask

    task automatic t_reset_mid;
        int w0;
        do_reset(1'b0, 1'b1);
        w0 = we_cnt;
        @(negedge clk);
        addr_in = 4'h2; ad_in = 8'h22; cs_n = 1'b0; wr_rw = 1'b0;
        cycles(6);
        rst_n = 1'b0;
        cycles(2);
        cs_n = 1'b1; wr_rw = 1'b1;
        cycles(3);
        rst_n = 1'b1;
        cycles(8);
        check(we_cnt == w0, "R10 no write after reset", we_cnt - w0, 0);
        check(ad_oe == 1'b0, "R1 oe low after mid reset", ad_oe, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 8'h00;
        t_reset_state();
        t_intel_sep();
        t_addr_sample();
        t_cs_high();
        t_moto_sep();
        t_mux(1'b1, 4'h9, 8'h77);
        t_mux(1'b0, 4'h6, 8'hC4);
        t_strap_hold();
        t_reset_mid();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule